// File: doc/BRIEF.md
# Single-Tape Machine Tableau Row Engine

This block keeps one row of a computation tableau for a fixed single-tape machine as a register array of `CELLS` cells. Each cell is a bank of one-hot indicator bits: one bit per plain tape symbol, and one bit per (state, symbol) pair that marks the head position together with the machine's current state. On every clock of a run, all cells are replaced at once by the next configuration. Each new cell is formed only from the old cells at the same column and at the two columns next to it. The result is a sum of products over those three neighbours: the terms that lead to a given symbol are ANDed, then ORed together.

A `load` pulse fills the row from a `WBITS`-bit input word and starts a run. The built-in machine decides odd parity. It marks the first cell and sweeps right while it tracks the parity, then turns back at the first blank. On reaching the mark it writes a blank over it and halts in an accept or a reject state. Once halted, the configuration repeats unchanged. After exactly `CELLS` updates the block raises `done`, and `accept` then reports whether the leftmost cell holds the accept state over a blank. The whole row is visible on `row_lights` for inspection.

Top module: `tm_tableau_row`

## Requirements
- R1: Each cell holds 32 indicator bits at `row_lights[32*j +: 32]` for cell j, and exactly one bit is set after reset. Plain symbols use index 0 for zero, 1 for one, 2 for blank and 3 for the mark. A head in state q over symbol s uses index 4 + 4*q + s. The states are 0 start, 1 even, 2 odd, 3 return-even, 4 return-odd, 5 accept and 6 reject.
- R2: On the clock edge where `load` is high, cell 0 takes index 4 + `word_in[0]` (start state over that bit). Cell j for 1 ≤ j < WBITS takes plain index `word_in[j]`. Every remaining cell takes index 2 (blank).
- R3: Each update uses only the left, same and right neighbours of a cell, and the end cells treat the missing neighbour as empty. At most one cell holds a head. At the end of a run, cells 1 to WBITS-1 still hold their loaded bits and cell WBITS holds blank.
- R4: After a run, `accept` is 1 exactly when `word_in` held an odd number of ones.
- R5: `done` goes high exactly `CELLS` clock edges after the loading edge, and not before.
- R6: `accept` is 0 whenever `done` is 0.
- R7: While `done` is high and `load` is low, the row and `accept` stay unchanged.
- R8: When `done` is high, cell 0 holds index 24+2=26 (accept over blank) for odd parity, or index 30 (reject over blank) for even parity.
- R9: Reset (synchronous, active high) sets every cell to blank (index 2) and clears `done` and `accept`.
- R10: A `load` during a run discards that run and restarts from the new word, with a full `CELLS`-edge wait before `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load the row from `word_in` and start a run |
| word_in | input | WBITS | Input word; bit 0 is the first symbol |
| done | output | 1 | High once `CELLS` updates have completed |
| accept | output | 1 | Machine accepted; meaningful only while `done` |
| row_lights | output | CELLS*32 | Indicator bits of every cell, cell 0 lowest |

## Verification
The bench targets several cases that a faulty design would handle wrongly:
- All-zero and all-one words, which make the head travel the longest path. An off-by-one in the run length shows up as a wrong `done` latency or as a halt short of cell 0.
- Words whose only one sits at either end. A design that drops the left or right neighbour at a boundary would lose the arriving head or corrupt the tape there, and the verdict would then be wrong.
- A reload in the middle of a run. A design that does not clear its step count would raise `done` early.
- The hold after halting. A design that keeps stepping once halted would change the row after `done`.

// File: rtl/tm_pkg.sv
package tm_pkg;

    localparam int NSYM   = 4;
    localparam int NST    = 7;
    localparam int NLIGHT = NSYM + NSYM * NST;

    localparam int SYM_ZERO  = 0;
    localparam int SYM_ONE   = 1;
    localparam int SYM_BLANK = 2;
    localparam int SYM_MARK  = 3;

    localparam int ST_START  = 0;
    localparam int ST_EVEN   = 1;
    localparam int ST_ODD    = 2;
    localparam int ST_BACK_E = 3;
    localparam int ST_BACK_O = 4;
    localparam int ST_ACC    = 5;
    localparam int ST_REJ    = 6;

    typedef logic [NLIGHT-1:0] light_t;

    typedef enum logic [1:0] {MV_STAY, MV_LEFT, MV_RIGHT} move_e;

    typedef struct packed {
        logic [2:0] nq;
        logic [1:0] wr;
        move_e      mv;
    } step_t;

    function automatic int comp_idx(int q, int s);
        return NSYM + q * NSYM + s;
    endfunction

    function automatic light_t plain(int s);
        light_t v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    function automatic step_t mk(int nq, int wr, move_e mv);
        step_t t;
        t.nq = 3'(nq);
        t.wr = 2'(wr);
        t.mv = mv;
        return t;
    endfunction

    // Fixed transition rule of the odd-parity machine.
    function automatic step_t delta(int q, int s);
        step_t t;
        case (q)
            ST_START: begin
                if (s == SYM_ZERO)     t = mk(ST_EVEN, SYM_MARK, MV_RIGHT);
                else if (s == SYM_ONE) t = mk(ST_ODD, SYM_MARK, MV_RIGHT);
                else                   t = mk(ST_REJ, s, MV_STAY);
            end
            ST_EVEN, ST_ODD: begin
                if (s == SYM_ZERO)       t = mk(q, SYM_ZERO, MV_RIGHT);
                else if (s == SYM_ONE)   t = mk((q == ST_ODD) ? ST_EVEN : ST_ODD, SYM_ONE, MV_RIGHT);
                else if (s == SYM_BLANK) t = mk((q == ST_ODD) ? ST_BACK_O : ST_BACK_E, SYM_BLANK, MV_LEFT);
                else                     t = mk(ST_REJ, s, MV_STAY);
            end
            ST_BACK_E, ST_BACK_O: begin
                if (s == SYM_ZERO || s == SYM_ONE) t = mk(q, s, MV_LEFT);
                else if (s == SYM_MARK)            t = mk((q == ST_BACK_O) ? ST_ACC : ST_REJ, SYM_BLANK, MV_STAY);
                else                               t = mk(ST_REJ, s, MV_STAY);
            end
            default: t = mk(q, s, MV_STAY);
        endcase
        return t;
    endfunction

    // Sum of products over neighbour lights; the far neighbour is a don't-care
    // in every product, so each term needs only two lights.
    function automatic light_t cell_next(light_t l, light_t m, light_t r);
        light_t nx;
        logic   arrive;
        step_t  d;
        int     k;
        nx     = '0;
        arrive = 1'b0;
        for (int q = 0; q < NST; q++) begin
            for (int s = 0; s < NSYM; s++) begin
                d = delta(q, s);
                k = comp_idx(q, s);
                for (int b = 0; b < NSYM; b++) begin
                    if (d.mv == MV_RIGHT) begin
                        nx[comp_idx(int'(d.nq), b)] |= l[k] & m[b];
                        arrive |= l[k] & m[b];
                    end
                    if (d.mv == MV_LEFT) begin
                        nx[comp_idx(int'(d.nq), b)] |= r[k] & m[b];
                        arrive |= r[k] & m[b];
                    end
                end
                if (d.mv == MV_STAY) nx[comp_idx(int'(d.nq), int'(d.wr))] |= m[k];
                else                 nx[int'(d.wr)] |= m[k];
            end
        end
        for (int b = 0; b < NSYM; b++) nx[b] |= m[b] & ~arrive;
        return nx;
    endfunction

endpackage

// File: rtl/tm_row_init.sv
module tm_row_init import tm_pkg::*; #(
    parameter int CELLS = 16,
    parameter int WBITS = 7
) (
    input  logic [WBITS-1:0]              word_in,
    output logic [CELLS-1:0][NLIGHT-1:0]  init_row
);
    always_comb begin
        init_row = '0;
        init_row[0][comp_idx(ST_START, SYM_ONE)]  = word_in[0];
        init_row[0][comp_idx(ST_START, SYM_ZERO)] = ~word_in[0];
        for (int j = 1; j < CELLS; j++) begin
            if (j < WBITS) begin
                init_row[j][SYM_ONE]  = word_in[j];
                init_row[j][SYM_ZERO] = ~word_in[j];
            end else begin
                init_row[j][SYM_BLANK] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tm_cell.sv
module tm_cell import tm_pkg::*; (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   step,
    input  light_t ld_val,
    input  light_t left_n,
    input  light_t right_n,
    output light_t cur
);
    always_ff @(posedge clk) begin
        if (rst)       cur <= plain(SYM_BLANK);
        else if (load) cur <= ld_val;
        else if (step) cur <= cell_next(left_n, cur, right_n);
    end

    AST_CELL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(cur)); // R1
endmodule

// File: rtl/tm_step_ctr.sv
module tm_step_ctr #(
    parameter int CELLS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CELLS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else if (load) begin
            cnt  <= '0;
            busy <= 1'b1;
            done <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(CELLS - 1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R5
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy)); // R5
endmodule

// File: rtl/tm_tableau_row.sv
module tm_tableau_row import tm_pkg::*; #(
    parameter int CELLS = 16,
    parameter int WBITS = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [WBITS-1:0]         word_in,
    output logic                     done,
    output logic                     accept,
    output logic [CELLS*NLIGHT-1:0]  row_lights
);
    localparam int ACC_LIGHT = NSYM + ST_ACC * NSYM + SYM_BLANK;

    logic [CELLS-1:0][NLIGHT-1:0] init_row;
    logic [CELLS-1:0][NLIGHT-1:0] row;
    logic [CELLS-1:0]             head_vec;
    logic                         busy;

    if (2 * WBITS + 1 > CELLS) begin : g_size_check
        $error("row too short for the input word");
    end

    tm_row_init #(.CELLS(CELLS), .WBITS(WBITS)) u_init (
        .word_in  (word_in),
        .init_row (init_row)
    );

    tm_step_ctr #(.CELLS(CELLS)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .busy (busy),
        .done (done)
    );

    for (genvar j = 0; j < CELLS; j++) begin : g_cell
        light_t lft, rgt;
        if (j == 0) begin : g_lb
            assign lft = '0;
        end else begin : g_li
            assign lft = row[j-1];
        end
        if (j == CELLS - 1) begin : g_rb
            assign rgt = '0;
        end else begin : g_ri
            assign rgt = row[j+1];
        end
        tm_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .step    (busy),
            .ld_val  (init_row[j]),
            .left_n  (lft),
            .right_n (rgt),
            .cur     (row[j])
        );
        assign head_vec[j] = |row[j][NLIGHT-1:NSYM];
    end

    assign accept     = done & row[0][ACC_LIGHT];
    assign row_lights = row;

    AST_ACCEPT_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        accept |-> done); // R6
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> $stable(row)); // R7
    AST_ONE_HEAD: assert property (@(posedge clk) disable iff (rst)
        $countones(head_vec) <= 1); // R3
    AST_LOAD_HEAD_HOME: assert property (@(posedge clk) disable iff (rst)
        load |=> head_vec[0]); // R2
endmodule

// File: tb/tb_tm_tableau_row.sv
module tb_tm_tableau_row;
    localparam int CLK_P = 10;
    localparam int T  = 16;
    localparam int N  = 7;
    localparam int NL = 32;
    localparam int NV = 8;
    localparam logic [N-1:0] VEC [NV] = '{
        7'b0000000, 7'b0000001, 7'b1000000, 7'b1111111,
        7'b1010101, 7'b0110100, 7'b1111110, 7'b0011001
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load = 1'b0;
    logic [N-1:0] word_in = '0;
    logic done, accept;
    logic [T*NL-1:0] row_lights;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    tm_tableau_row #(.CELLS(T), .WBITS(N)) dut (
        .clk(clk), .rst(rst), .load(load), .word_in(word_in),
        .done(done), .accept(accept), .row_lights(row_lights)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic lit(int j, int k);
        return row_lights[j*NL + k];
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Start a run; returns number of edges after the loading edge until done.
    task automatic run_word(input logic [N-1:0] w, output int lat, output int bad_cells, output int bad_heads);
        @(negedge clk);
        load = 1'b1; word_in = w;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        lat = -1; bad_cells = 0; bad_heads = 0;
        for (int k = 1; k <= T + 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            begin
                int heads = 0;
                for (int j = 0; j < T; j++) begin
                    int ones = 0;
                    for (int b = 0; b < NL; b++) ones += int'(lit(j, b));
                    if (ones != 1) bad_cells++;
                    for (int b = 4; b < NL; b++) heads += int'(lit(j, b));
                end
                if (heads > 1) bad_heads++;
            end
            if (done) begin
                lat = k;
                break;
            end
        end
    endtask

    initial begin
        int lat, bc, bh, bad;
        logic [T*NL-1:0] snap;
        logic exp_acc;

        // Reset state (R9)
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(done == 1'b0, "R9 done after reset", int'(done), 0);
        chk(accept == 1'b0, "R9 accept after reset", int'(accept), 0);
        bad = 0;
        for (int j = 0; j < T; j++) if (!lit(j, 2)) bad++;
        chk(bad == 0, "R9 blank cells after reset", bad, 0);

        // Load layout (R2)
        @(negedge clk);
        load = 1'b1; word_in = 7'b1000001;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        chk(lit(0, 5) == 1'b1, "R2 cell0 start-over-one", int'(lit(0, 5)), 1);
        bad = 0;
        for (int j = 1; j < N; j++) if (!lit(j, int'(word_in[j]))) bad++;
        for (int j = N; j < T; j++) if (!lit(j, 2)) bad++;
        chk(bad == 0, "R2 tape cells after load", bad, 0);
        chk(accept == 1'b0, "R6 accept low during run", int'(accept), 0);

        // Vector table (R1 R3 R4 R5 R8)
        for (int v = 0; v < NV; v++) begin
            exp_acc = ^VEC[v];
            run_word(VEC[v], lat, bc, bh);
            chk(lat == T, "R5 done latency", lat, T);
            chk(accept == exp_acc, "R4 parity verdict", int'(accept), int'(exp_acc));
            chk(bc == 0, "R1 one-hot cells", bc, 0);
            chk(bh == 0, "R3 single head", bh, 0);
            chk(lit(0, exp_acc ? 26 : 30) == 1'b1, "R8 cell0 final light",
                int'(lit(0, exp_acc ? 26 : 30)), 1);
            bad = 0;
            for (int j = 1; j < N; j++) if (!lit(j, int'(VEC[v][j]))) bad++;
            if (!lit(N, 2)) bad++;
            chk(bad == 0, "R3 tape kept", bad, 0);
        end

        // Halt hold (R7)
        snap = row_lights;
        exp_acc = accept;
        repeat (5) @(negedge clk);
        chk(row_lights == snap, "R7 row stable after done", 0, 0);
        chk(accept == exp_acc && done, "R7 accept held", int'(accept), int'(exp_acc));

        // Restart mid-run (R10)
        @(negedge clk);
        load = 1'b1; word_in = 7'b0000001;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        repeat (5) @(negedge clk);
        chk(done == 1'b0, "R6 done low mid-run", int'(done), 0);
        chk(accept == 1'b0, "R6 accept low mid-run", int'(accept), 0);
        run_word(7'b0000011, lat, bc, bh);
        chk(lat == T, "R10 latency after reload", lat, T);
        chk(accept == 1'b0, "R10 verdict from new word", int'(accept), 0);

        // Boundary word with a single one at the far end (R4)
        run_word(7'b1000000, lat, bc, bh);
        chk(accept == 1'b1, "R4 far-end one", int'(accept), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule